// File: doc/BRIEF.md
# Credit-Gated Subpartition to DRAM Arbiter

This block sits between several cache subpartition request queues and a single DRAM channel. In each cycle it looks at the head entry of every subpartition queue, picks at most one by rotating priority, and hands it to the DRAM controller. Each head entry carries a valid flag and a read/write bit. The DRAM side reports two separate full conditions, one for reads and one for writes. If the request that wins the search targets a full queue, nothing is issued in that cycle.

Issue is limited by credits. Every subpartition owns one private credit. All subpartitions also draw on a shared pool whose size is derived from the DRAM read-queue depth, the return-queue depth and the subpartition count. When a separate DRAM write queue is configured, its depth is added to the pool. A completion pulse tagged with a subpartition id returns one credit. If that subpartition borrowed from the pool, the credit goes back to the pool; otherwise its private credit is freed.

Input handshake: a subpartition's head entry leaves its queue in a cycle where both `sp_valid[i]` and `sp_ready[i]` are high. `sp_ready` is high for the granted subpartition only and depends on that subpartition's own `sp_valid`. The output has no ready signal. Back-pressure from the DRAM reaches the arbiter only through the two full flags, and `out_valid` is never high for a request type whose full flag is set.

Top module: `sp_dram_arbiter`

## Requirements
- R1: After reset every private credit is free, the shared pool is empty, and the rotating pointer points at the highest index, so subpartition 0 is searched first. With no valid input, `out_valid` and `sp_ready` stay low.
- R2: The search starts at the subpartition after the one that issued last and wraps modulo NUM_SP.
- R3: A subpartition is eligible only if `sp_valid` is high and it has a credit. A credit is available when its private credit is free or the shared pool holds fewer than SHARED_LIMIT borrowed credits. Ineligible subpartitions are skipped.
- R4: If the first eligible subpartition's head is a write (`sp_is_wr`=1) and `dram_wr_full` is set, or a read (`sp_is_wr`=0) and `dram_rd_full` is set, nothing issues that cycle and later subpartitions are not tried.
- R5: At most one request issues per cycle. When `out_valid` is high, `sp_ready` equals one-hot of `out_sp_id`, and `out_is_wr` equals that subpartition's `sp_is_wr`. Otherwise `sp_ready` is zero.
- R6: An issue uses the subpartition's private credit if that credit is free, and a shared credit otherwise.
- R7: SHARED_LIMIT = RDQ_DEPTH + RETQ_DEPTH − (NUM_SP − 1), plus WRQ_DEPTH when SEP_WRQ is 1. With the defaults (4, 8, 4, 6, 1) this is 15, so one subpartition alone can issue 16 times before it stalls.
- R8: A completion (`done_valid` with `done_sp_id`) returns a shared credit if that subpartition holds a borrowed one, and frees its private credit otherwise.
- R9: A completion for a subpartition with nothing outstanding has no effect on any credit.
- R10: The rotating pointer moves only in a cycle in which a request issues. Idle or blocked cycles leave it unchanged.
- R11: An issue and a completion in the same cycle both take effect on the shared pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sp_valid | input | NUM_SP | Head entry present, one bit per subpartition |
| sp_is_wr | input | NUM_SP | Head entry is a write (1) or a read (0) |
| sp_ready | output | NUM_SP | One-hot grant; pops the granted head entry |
| dram_rd_full | input | 1 | DRAM read queue cannot accept |
| dram_wr_full | input | 1 | DRAM write queue cannot accept |
| out_valid | output | 1 | A request is issued to DRAM this cycle |
| out_sp_id | output | IDW | Subpartition of the issued request |
| out_is_wr | output | 1 | Type of the issued request |
| done_valid | input | 1 | DRAM completion pulse |
| done_sp_id | input | IDW | Subpartition the completion belongs to |

## Verification
Two functions can land in the same cycle: a new issue that takes a shared credit, and a completion that returns one. The bench first drives the pool to exactly one free slot. It then presents a borrowing request together with a completion for a subpartition that holds borrowed credits. Both updates are judged by counting how many further issues the pool allows before it stalls: exactly one more issue, then a stall.

// File: rtl/sp_arb_pkg.sv
package sp_arb_pkg;

  // Shared credit pool size from queue depths; clamped at zero.
  function automatic int pool_limit(input int rdq, input int retq, input int nsp,
                                    input int wrq, input bit sep);
    int v;
    v = rdq + retq - (nsp - 1);
    if (sep) v = v + wrq;
    if (v < 0) v = 0;
    return v;
  endfunction

  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sp_credit_slot.sv
// Private credit and borrow count for one subpartition.
module sp_credit_slot #(
  parameter int CW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,       // this subpartition issued this cycle
  input  logic done,        // completion addressed to this subpartition
  input  logic pool_room,   // shared pool can lend one more credit
  output logic has_credit,
  output logic take_shared,
  output logic rel_shared
);
  logic          priv_used_q;
  logic [CW-1:0] borrow_q;
  logic          take_priv;
  logic          rel_priv;

  assign has_credit  = !priv_used_q || pool_room;
  assign take_priv   = grant && !priv_used_q;
  assign take_shared = grant && priv_used_q;
  assign rel_shared  = done && (borrow_q != '0);
  assign rel_priv    = done && (borrow_q == '0) && priv_used_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_used_q <= 1'b0;
      borrow_q    <= '0;
    end else begin
      if (take_priv)     priv_used_q <= 1'b1;
      else if (rel_priv) priv_used_q <= 1'b0;
      borrow_q <= borrow_q + CW'(take_shared) - CW'(rel_shared);
    end
  end
endmodule

// File: rtl/sp_shared_pool.sv
// Counts credits lent out of the shared pool.
module sp_shared_pool #(
  parameter int LIMIT = 15,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          give_back,
  output logic          room,
  output logic [CW-1:0] used
);
  logic [CW-1:0] used_q;

  assign used = used_q;

  generate
    if (LIMIT == 0) begin : g_empty
      assign room = 1'b0;
    end else begin : g_count
      assign room = (used_q < CW'(LIMIT));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_q + CW'(take) - CW'(give_back);
  end
endmodule

// File: rtl/sp_rr_pick.sv
// Rotating-priority search starting after the last winner.
module sp_rr_pick #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic [N-1:0]   elig,
  input  logic [IDW-1:0] last,
  output logic           found,
  output logic [IDW-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(last) + 1 + k) % N;
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = IDW'(idx);
      end
    end
  end
endmodule

// File: rtl/sp_dram_arbiter.sv
module sp_dram_arbiter
  import sp_arb_pkg::*;
#(
  parameter int NUM_SP     = 4,
  parameter int RDQ_DEPTH  = 8,
  parameter int RETQ_DEPTH = 4,
  parameter int WRQ_DEPTH  = 6,
  parameter bit SEP_WRQ    = 1'b1,
  localparam int IDW       = width_of(NUM_SP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SP-1:0] sp_valid,
  input  logic [NUM_SP-1:0] sp_is_wr,
  output logic [NUM_SP-1:0] sp_ready,
  input  logic              dram_rd_full,
  input  logic              dram_wr_full,
  output logic              out_valid,
  output logic [IDW-1:0]    out_sp_id,
  output logic              out_is_wr,
  input  logic              done_valid,
  input  logic [IDW-1:0]    done_sp_id
);
  localparam int SHARED_LIMIT = pool_limit(RDQ_DEPTH, RETQ_DEPTH, NUM_SP, WRQ_DEPTH, SEP_WRQ);
  localparam int CW           = width_of(SHARED_LIMIT + 1);

  logic [NUM_SP-1:0] has_credit, take_sh, rel_sh, grant_vec, done_vec, elig;
  logic              pool_room;
  logic [CW-1:0]     pool_cnt;
  logic [IDW-1:0]    last_q;
  logic              found;
  logic [IDW-1:0]    pick;
  logic              pick_wr;
  logic              blocked;
  logic              fire;

  assign elig = sp_valid & has_credit;

  sp_rr_pick #(.N(NUM_SP), .IDW(IDW)) u_pick (
    .elig  (elig),
    .last  (last_q),
    .found (found),
    .pick  (pick)
  );

  // The first eligible head decides; a full target queue ends the cycle.
  assign pick_wr = sp_is_wr[pick];
  assign blocked = pick_wr ? dram_wr_full : dram_rd_full;
  assign fire    = found && !blocked;

  assign out_valid = fire;
  assign out_sp_id = pick;
  assign out_is_wr = pick_wr;

  generate
    for (genvar i = 0; i < NUM_SP; i++) begin : g_slot
      assign grant_vec[i] = fire && (pick == IDW'(i));
      assign done_vec[i]  = done_valid && (done_sp_id == IDW'(i));

      sp_credit_slot #(.CW(CW)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant       (grant_vec[i]),
        .done        (done_vec[i]),
        .pool_room   (pool_room),
        .has_credit  (has_credit[i]),
        .take_shared (take_sh[i]),
        .rel_shared  (rel_sh[i])
      );
    end
  endgenerate

  assign sp_ready = grant_vec;

  sp_shared_pool #(.LIMIT(SHARED_LIMIT), .CW(CW)) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (|take_sh),
    .give_back (|rel_sh),
    .room      (pool_room),
    .used      (pool_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= IDW'(NUM_SP - 1);
    else if (fire) last_q <= pick;
  end
endmodule

// File: rtl/sp_dram_arbiter_chk.sv
module sp_dram_arbiter_chk #(
  parameter int NUM_SP = 4,
  parameter int IDW    = 2,
  parameter int CW     = 4,
  parameter int LIMIT  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_SP-1:0] sp_valid,
  input logic [NUM_SP-1:0] sp_is_wr,
  input logic [NUM_SP-1:0] sp_ready,
  input logic              dram_rd_full,
  input logic              dram_wr_full,
  input logic              out_valid,
  input logic [IDW-1:0]    out_sp_id,
  input logic              out_is_wr,
  input logic [IDW-1:0]    last_q,
  input logic [CW-1:0]     pool_cnt
);
  p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sp_ready) && (out_valid == (|sp_ready)));

  p_grant_matches_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sp_ready[out_sp_id] && out_is_wr == sp_is_wr[out_sp_id]));

  p_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> sp_valid[out_sp_id]);

  p_no_write_into_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_wr) |-> !dram_wr_full);

  p_no_read_into_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_wr) |-> !dram_rd_full);

  p_pool_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pool_cnt <= CW'(LIMIT));

  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !out_valid) |=> $stable(last_q));

  p_ptr_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && out_valid) |=> (last_q == $past(out_sp_id)));
endmodule

bind sp_dram_arbiter sp_dram_arbiter_chk #(
  .NUM_SP (NUM_SP),
  .IDW    (IDW),
  .CW     (CW),
  .LIMIT  (SHARED_LIMIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sp_valid     (sp_valid),
  .sp_is_wr     (sp_is_wr),
  .sp_ready     (sp_ready),
  .dram_rd_full (dram_rd_full),
  .dram_wr_full (dram_wr_full),
  .out_valid    (out_valid),
  .out_sp_id    (out_sp_id),
  .out_is_wr    (out_is_wr),
  .last_q       (last_q),
  .pool_cnt     (pool_cnt)
);

// File: tb/sp_dram_arbiter_tb.sv
module sp_dram_arbiter_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] sp_valid, sp_is_wr, sp_ready;
  logic         dram_rd_full, dram_wr_full;
  logic         out_valid, out_is_wr;
  logic [1:0]   out_sp_id;
  logic         done_valid;
  logic [1:0]   done_sp_id;
  int           total = 0;
  int           bad   = 0;

  always #4 clk = ~clk;   // 125 MHz

  sp_dram_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .sp_valid(sp_valid), .sp_is_wr(sp_is_wr),
    .sp_ready(sp_ready), .dram_rd_full(dram_rd_full), .dram_wr_full(dram_wr_full),
    .out_valid(out_valid), .out_sp_id(out_sp_id), .out_is_wr(out_is_wr),
    .done_valid(done_valid), .done_sp_id(done_sp_id)
  );

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sp_valid = '0; sp_is_wr = '0;
    dram_rd_full = 1'b0; dram_wr_full = 1'b0; done_valid = 1'b0; done_sp_id = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One cycle: drive at the falling edge, judge the outputs, commit at the rising edge.
  // Every call also checks R5: sp_ready must equal one-hot of the expected winner.
  task automatic cyc(input logic [N-1:0] v, input logic [N-1:0] w, input logic rf,
                     input logic wf, input logic dv, input logic [1:0] did,
                     input logic ev, input logic [1:0] eid, input string tag);
    logic ok;
    @(negedge clk);
    sp_valid = v; sp_is_wr = w; dram_rd_full = rf; dram_wr_full = wf;
    done_valid = dv; done_sp_id = did;
    #1;
    total++;
    if (ev) ok = out_valid && (out_sp_id == eid) && (out_is_wr == w[eid]) &&
                 (sp_ready == (N'(1) << eid));
    else    ok = !out_valid && (sp_ready == '0);
    if (!ok) begin
      bad++;
      $display("FAIL %s (R5 grant form): valid=%0b id=%0d wr=%0b ready=%b, expected valid=%0b id=%0d ready=%b",
               tag, out_valid, out_sp_id, out_is_wr, sp_ready, ev, eid,
               ev ? (N'(1) << eid) : '0);
    end
    @(posedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    cyc(4'b0000, 4'b0000, 0, 0, 0, 0, 0, 0, "R1 idle after reset");
    cyc(4'b1111, 4'b0000, 0, 0, 0, 0, 1, 0, "R1 sp0 first");
  endtask

  task automatic t_rr();
    do_reset();
    cyc(4'b1111, 4'b0000, 0, 0, 0, 0, 1, 0, "R2 order 0");
    cyc(4'b1111, 4'b0010, 0, 0, 0, 0, 1, 1, "R2 order 1");
    cyc(4'b1111, 4'b0000, 0, 0, 0, 0, 1, 2, "R2 order 2");
    cyc(4'b1111, 4'b1000, 0, 0, 0, 0, 1, 3, "R2 order 3");
    cyc(4'b1111, 4'b0000, 0, 0, 0, 0, 1, 0, "R2 wrap to 0");
    cyc(4'b0000, 4'b0000, 0, 0, 0, 0, 0, 0, "R10 idle");
    cyc(4'b1111, 4'b0000, 0, 0, 0, 0, 1, 1, "R10 pointer held");
    cyc(4'b0101, 4'b0000, 0, 0, 0, 0, 1, 2, "R2 skip non-valid");
  endtask

  task automatic t_full();
    do_reset();
    cyc(4'b0011, 4'b0001, 0, 1, 0, 0, 0, 0, "R4 write full blocks sp1");
    cyc(4'b0011, 4'b0001, 1, 0, 0, 0, 1, 0, "R4 R10 sp0 after block");
    cyc(4'b0010, 4'b0000, 1, 0, 0, 0, 0, 0, "R4 read full");
    cyc(4'b0010, 4'b0000, 0, 0, 0, 0, 1, 1, "R4 read released");
  endtask

  task automatic t_credit();
    do_reset();
    for (int i = 0; i < 16; i++)
      cyc(4'b0001, 4'b0000, 0, 0, 0, 0, 1, 0, "R7 R6 sp0 private then pool");
    cyc(4'b0001, 4'b0000, 0, 0, 0, 0, 0, 0, "R7 pool exhausted");
    cyc(4'b1000, 4'b0000, 0, 0, 0, 0, 1, 3, "R6 private credit");
    cyc(4'b0011, 4'b0001, 0, 1, 0, 0, 1, 1, "R3 creditless sp0 skipped");
    cyc(4'b0010, 4'b0000, 0, 0, 0, 0, 0, 0, "R3 no credit");
  endtask

  task automatic t_done();
    do_reset();
    for (int i = 0; i < 16; i++)
      cyc(4'b0001, 4'b0000, 0, 0, 0, 0, 1, 0, "R6 fill pool");
    cyc(4'b0010, 4'b0000, 0, 0, 0, 0, 1, 1, "R6 sp1 private");
    cyc(4'b0000, 4'b0000, 0, 0, 1, 2, 0, 0, "R9 stray completion");
    cyc(4'b0010, 4'b0000, 0, 0, 0, 0, 0, 0, "R9 pool unchanged");
    cyc(4'b0000, 4'b0000, 0, 0, 1, 1, 0, 0, "R8 complete sp1");
    cyc(4'b0010, 4'b0000, 0, 0, 0, 0, 1, 1, "R8 private freed");
    cyc(4'b0000, 4'b0000, 0, 0, 1, 0, 0, 0, "R8 complete sp0");
    cyc(4'b0010, 4'b0000, 0, 0, 0, 0, 1, 1, "R8 shared returned first");
    cyc(4'b0010, 4'b0000, 0, 0, 0, 0, 0, 0, "R8 pool full again");
    cyc(4'b0000, 4'b0000, 0, 0, 1, 0, 0, 0, "R11 open one slot");
    cyc(4'b0010, 4'b0000, 0, 0, 1, 0, 1, 1, "R11 issue with completion");
    cyc(4'b0010, 4'b0000, 0, 0, 0, 0, 1, 1, "R11 one slot left");
    cyc(4'b0010, 4'b0000, 0, 0, 0, 0, 0, 0, "R11 then full");
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_rr();
    t_full();
    t_credit();
    t_done();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule